// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit

This block is the multiplier and accumulator datapath of a small 16-bit signal processor. It holds two signed operand registers, X and Y. A 32-bit product register P always holds twice their product, which places the result in fractional (Q1.15 × Q1.15 → Q1.31) form. Writing either operand refreshes P on the same clock edge. The three arithmetic operations load both operands at once. Each of them then either clears the 32-bit accumulator A, adds the old P to A, or subtracts the old P from A, and loads P with the new product in the same cycle.

Because every accumulate consumes the P from the previous operation, a chain of multiply-add operations forms a one-stage pipeline. The first operation of a chain is normally a clear-and-multiply. After each add or subtract, the unit updates four arithmetic flags in a 16-bit status word. The low twelve bits of that word are left alone by the arithmetic. The surrounding core can write the whole word.

Top module: `fxp_mac`

## Requirements
- R1: After reset, acc, prod and status are all zero, and the X and Y operand registers are zero.
- R2: When x_we (or y_we) is high and op_valid is not, wr_data is loaded into X (or Y). On that same edge prod becomes 2·X·Y, computed from the new operand values as signed two's-complement numbers and wrapped modulo 2^32. In a cycle with no operand write and no operation, prod is unchanged.
- R3: op_sel = 2'b00 (clear and multiply) with op_valid sets acc to zero. It loads X from op_a and Y from op_b and sets prod to 2·op_a·op_b. The status word does not change.
- R4: op_sel = 2'b01 (multiply-add) sets acc to acc + prod, using the prod value from before the edge. It then loads X, Y and prod as in R3.
- R5: op_sel = 2'b10 (multiply-subtract) sets acc to acc − prod, using the prod value from before the edge. It then loads X, Y and prod as in R3.
- R6: op_sel = 2'b11 is reserved. With no operand write in the same cycle, it leaves acc, prod and status unchanged.
- R7: After an add or subtract, status bit 15 (N) equals bit 31 of the new acc. Status bit 13 (Z) is set exactly when the new acc is zero.
- R8: After an add or subtract, status bit 14 (V) is set when the true signed result lies outside the 32-bit two's-complement range. Status bit 12 (L) holds the carry out of bit 31 for an add, and the borrow for a subtract (old acc below old prod as unsigned values).
- R9: st_we loads st_wdata into status. If an add or subtract happens in the same cycle, bits 15:12 take the new flags and bits 11:0 take st_wdata. Without st_we, bits 11:0 never change.
- R10: A valid operation takes priority over x_we and y_we in the same cycle: the operands come from op_a and op_b.
- R11: The product of −32768 by −32768 gives prod = 32'h8000_0000 (the doubling wraps).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| x_we | input | 1 | Write wr_data into X |
| y_we | input | 1 | Write wr_data into Y |
| wr_data | input | 16 | Operand write data |
| op_valid | input | 1 | Perform the operation on op_sel |
| op_sel | input | 2 | 00 clear, 01 add, 10 subtract, 11 reserved |
| op_a | input | 16 | Operand for X in an operation |
| op_b | input | 16 | Operand for Y in an operation |
| st_we | input | 1 | Write st_wdata into status |
| st_wdata | input | 16 | Status write data |
| acc | output | 32 | Accumulator A |
| prod | output | 32 | Product register P |
| status | output | 16 | Status word with flags in bits 15:12 |

## Verification
The bench drives accumulate chains where the old-versus-new P ordering matters. A design that used the fresh product would accumulate the wrong value on every step after a clear. The −32768 squared case catches a design that saturates the product or sign-extends the doubling, because such a design would produce 0x7FFFFFFF or a negative wide value instead of 0x80000000. Two negative sums that wrap to zero set Z, V and L together, and a small subtract that borrows sets N and L; a flag placed in the wrong bit or a swapped carry polarity shows up in these cases. A status write that coincides with an add checks the merge: a design that let the write win, or that dropped the control bits, fails it.

// File: rtl/fxp_mac.sv
module fxp_mac #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            x_we,
  input  logic            y_we,
  input  logic [DW-1:0]   wr_data,
  input  logic            op_valid,
  input  logic [1:0]      op_sel,
  input  logic [DW-1:0]   op_a,
  input  logic [DW-1:0]   op_b,
  input  logic            st_we,
  input  logic [15:0]     st_wdata,
  output logic [2*DW-1:0] acc,
  output logic [2*DW-1:0] prod,
  output logic [15:0]     status
);
  localparam int AW = 2 * DW;
  localparam logic [1:0] OP_CLR = 2'b00;
  localparam logic [1:0] OP_ADD = 2'b01;
  localparam logic [1:0] OP_SUB = 2'b10;

  logic [DW-1:0] x_q, y_q;

  wire do_op  = op_valid && (op_sel != 2'b11);
  wire do_acc = do_op && (op_sel != OP_CLR);
  wire is_sub = (op_sel == OP_SUB);

  wire [DW-1:0] nx = do_op ? op_a : (x_we ? wr_data : x_q);
  wire [DW-1:0] ny = do_op ? op_b : (y_we ? wr_data : y_q);

  wire signed [AW-1:0] mul = $signed(nx) * $signed(ny);
  wire [AW-1:0] dbl = mul << 1;

  wire [AW:0] sum = is_sub ? ({1'b0, acc} - {1'b0, prod})
                           : ({1'b0, acc} + {1'b0, prod});
  wire [AW-1:0] res = sum[AW-1:0];
  wire sa = acc[AW-1];
  wire sp = prod[AW-1];
  wire sr = res[AW-1];
  wire ovf = is_sub ? ((sa != sp) && (sr != sa)) : ((sa == sp) && (sr != sa));
  wire [3:0] flags = {sr, ovf, (res == '0), sum[AW]};
  wire [15:0] st_base = st_we ? st_wdata : status;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      acc    <= '0;
      prod   <= '0;
      status <= '0;
    end else begin
      x_q <= nx;
      y_q <= ny;
      if (do_op || x_we || y_we) prod <= dbl;
      if (do_op) acc <= (op_sel == OP_CLR) ? '0 : res;
      status <= do_acc ? {flags, st_base[11:0]} : st_base;
    end
  end

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_CLR && !st_we) |=> (acc == '0 && $stable(status)));

  p_add_old_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_ADD) |=> (acc == $past(acc) + $past(prod)));

  p_sub_old_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_SUB) |=> (acc == $past(acc) - $past(prod)));

  p_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 2'b11 && !x_we && !y_we && !st_we)
      |=> ($stable(acc) && $stable(prod) && $stable(status)));

  p_prod_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !x_we && !y_we) |=> $stable(prod));

  p_nz_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_sel == OP_ADD || op_sel == OP_SUB))
      |=> (status[15] == acc[AW-1] && status[13] == (acc == '0)));

  p_ctl_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !st_we |=> (status[11:0] == $past(status[11:0])));
endmodule

// File: tb/fxp_mac_tb_top.sv
module fxp_mac_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x_we = 0, y_we = 0, op_valid = 0, st_we = 0;
  logic [15:0] wr_data = '0, op_a = '0, op_b = '0, st_wdata = '0;
  logic [1:0] op_sel = '0;
  logic [31:0] acc, prod;
  logic [15:0] status;

  int checks = 0;
  int fails = 0;
  logic [15:0] mx = '0, my = '0, mst = '0;
  logic [31:0] ma = '0, mp = '0;
  typedef struct packed { logic [31:0] a; logic [31:0] p; logic [15:0] s; logic [7:0] tag; } exp_t;
  exp_t q[$];
  bit done = 0;

  always #10 clk = ~clk;

  fxp_mac dut_i (
    .clk(clk), .rst_n(rst_n), .x_we(x_we), .y_we(y_we), .wr_data(wr_data),
    .op_valid(op_valid), .op_sel(op_sel), .op_a(op_a), .op_b(op_b),
    .st_we(st_we), .st_wdata(st_wdata), .acc(acc), .prod(prod), .status(status)
  );

  function automatic logic [31:0] twice(logic [15:0] a, logic [15:0] b);
    int t;
    t = int'($signed(a)) * int'($signed(b));
    return 32'(t) << 1;
  endfunction

  task automatic step(input logic xw, input logic yw, input logic [15:0] d,
                      input logic ov, input logic [1:0] os, input logic [15:0] oa,
                      input logic [15:0] ob, input logic sw, input logic [15:0] sd,
                      input logic [7:0] tag);
    logic [15:0] nx, ny;
    logic [32:0] s;
    longint t;
    logic f_l, f_v;
    exp_t e;
    @(negedge clk);
    x_we = xw; y_we = yw; wr_data = d; op_valid = ov; op_sel = os;
    op_a = oa; op_b = ob; st_we = sw; st_wdata = sd;
    nx = mx; ny = my;
    if (ov && os != 2'b11) begin nx = oa; ny = ob; end
    else begin if (xw) nx = d; if (yw) ny = d; end
    if (sw) mst = sd;
    if (ov && (os == 2'b01 || os == 2'b10)) begin
      if (os == 2'b01) begin
        s = {1'b0, ma} + {1'b0, mp};
        t = longint'($signed(ma)) + longint'($signed(mp));
        f_l = s[32];
      end else begin
        s = {1'b0, ma} - {1'b0, mp};
        t = longint'($signed(ma)) - longint'($signed(mp));
        f_l = (ma < mp);
      end
      f_v = (t > 64'sd2147483647) || (t < -64'sd2147483648);
      ma = s[31:0];
      mst[15] = ma[31]; mst[14] = f_v; mst[13] = (ma == 0); mst[12] = f_l;
    end else if (ov && os == 2'b00) ma = '0;
    if ((ov && os != 2'b11) || xw || yw) mp = twice(nx, ny);
    mx = nx; my = ny;
    e.a = ma; e.p = mp; e.s = mst; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input logic [7:0] tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (acc !== e.a || prod !== e.p || status !== e.s) begin
        fails++;
        $display("FAIL R%0d: acc=%h prod=%h st=%h expected acc=%h prod=%h st=%h",
                 e.tag, acc, prod, status, e.a, e.p, e.s);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    checks++;
    if (acc !== 0 || prod !== 0 || status !== 0) begin
      fails++;
      $display("FAIL R1: acc=%h prod=%h st=%h expected all zero", acc, prod, status);
    end
    step(1, 0, 16'd3, 0, 0, 0, 0, 0, 0, 8'd2);            // R2 X write, Y=0
    step(0, 1, 16'd5, 0, 0, 0, 0, 0, 0, 8'd2);            // R2 P=30
    step(1, 1, 16'hFFFE, 0, 0, 0, 0, 0, 0, 8'd2);         // R2 both -> 8
    idle(8'd2);                                           // R2 hold
    step(0, 0, 0, 1, 2'b00, 16'h4000, 16'h4000, 0, 0, 8'd3); // R3 clear
    step(0, 0, 0, 1, 2'b01, 16'd1, 16'd1, 0, 0, 8'd4);    // R4 add old P
    step(0, 0, 0, 1, 2'b10, 16'd0, 16'd0, 0, 0, 8'd5);    // R5 sub old P
    step(0, 0, 0, 1, 2'b10, 16'd7, 16'hFFFD, 0, 0, 8'd7); // R7 sub zero P
    step(0, 0, 0, 1, 2'b00, 16'd1, 16'd1, 0, 0, 8'd3);    // R3 clear, flags kept
    step(0, 0, 0, 1, 2'b10, 16'd2, 16'd2, 0, 0, 8'd8);    // R8 borrow, N set
    step(0, 0, 0, 1, 2'b11, 16'd9, 16'd9, 0, 0, 8'd6);    // R6 reserved
    step(0, 0, 0, 1, 2'b00, 16'h8000, 16'h8000, 0, 0, 8'd11); // R11 wrap
    step(0, 0, 0, 1, 2'b01, 16'h8000, 16'h8000, 0, 0, 8'd8);  // R8 add
    step(0, 0, 0, 1, 2'b01, 16'h0003, 16'h0002, 0, 0, 8'd8);  // R8 V,Z,L
    step(1, 1, 16'h1234, 1, 2'b01, 16'd2, 16'd3, 0, 0, 8'd10); // R10 op wins
    step(0, 0, 0, 0, 0, 0, 0, 1, 16'h0ABC, 8'd9);         // R9 status write
    step(0, 0, 0, 1, 2'b10, 16'd1, 16'd1, 1, 16'hF3FF, 8'd9); // R9 merge
    step(0, 0, 0, 1, 2'b01, 16'h7FFF, 16'h7FFF, 0, 0, 8'd9);  // R9 ctl kept
    step(1, 0, 16'hFFFF, 0, 0, 0, 0, 0, 0, 8'd2);         // R2 neg X
    idle(8'd2);
    idle(8'd2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule